// File: doc/BRIEF.md
# Processor-to-Reconfiguration-Port Bridge

This block is a small memory-mapped register slave that lets a processor reach the dynamic reconfiguration port of a clock synthesizer. It holds an enable register and an input-clock select register, and it turns one write to a control register into exactly one access on the reconfiguration port. That access is either a read or a write of a 16-bit word at a 7-bit port address.

Software writes a control word that carries four things together: a select flag, a read request flag, the port address and the write data. While the port access is in flight, a busy flag in the status register stays set. When the port returns its ready strobe, the busy flag drops. On a read, the status register also holds the returned word in its low half.

The processor bus is single-cycle. A write is taken on the clock edge where its strobe is high. Read data is driven combinationally while the read strobe is high.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, every mapped register reads zero. `core_enable`, `synth_enable`, `clk_sel`, `drp_en` and `drp_we` are all low.
- R2: The enable register is at offset 0x40. Bit 0 drives `core_enable` and bit 1 drives `synth_enable`. Both read back as written. All other bits read 0.
- R3: The clock select register is at offset 0x44. Bit 0 drives `clk_sel` and reads back. All other bits read 0.
- R4: The control register is at offset 0x70. When idle, a write to it with bit 29 set starts one port access. `drp_en` is high for exactly one clock, in the cycle after the write. `drp_addr` comes from bits 22:16 and `drp_di` from bits 15:0.
- R5: `drp_we` is high together with `drp_en` when bit 28 of the launching word is 0 (a port write). It stays low when bit 28 is 1 (a port read), and it is never high without `drp_en`.
- R6: The status register is at offset 0x74. Its bit 16 (busy) reads 1 from the cycle after the launching write up to and including the cycle in which `drp_rdy` is high. It reads 0 from the following cycle on.
- R7: On completion of a read access, the `drp_do` value present with `drp_rdy` appears in status bits 15:0. A write access leaves those bits unchanged.
- R8: A control write with bit 29 clear causes no port access. Busy stays 0 and the control readback does not change.
- R9: A control write that arrives while busy is ignored. It causes no extra `drp_en` pulse, no change of address or data, and no change of the control readback.
- R10: The control register reads back the last launched word masked to bits 29, 28, 22:16 and 15:0.
- R11: `bus_rdata` is zero for unmapped offsets and whenever `bus_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | BUS_AW | Byte offset of the access |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| core_enable | output | 1 | Enable register bit 0, releases reset of the clocking logic |
| synth_enable | output | 1 | Enable register bit 1, enables the synthesizer |
| clk_sel | output | 1 | Active input clock index |
| drp_en | output | 1 | Port access strobe |
| drp_we | output | 1 | Port write enable |
| drp_addr | output | 7 | Port register address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_rdy | input | 1 | Port ready strobe |

## Verification
The bench builds the block with its default 8-bit bus offset and the fixed 7-bit, 16-bit port widths. This puts the whole 128-entry port address space within reach of a sweep: every address is written through the bridge and then read back through it. A behavioural port model answers with a latency that changes from access to access (0 to 3, and 5). This exercises the exact length of the busy window for each latency. The long-latency case also opens a window in which to try an overlapping control write while busy and to check that it is dropped.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
    localparam int DRP_AW = 7;
    localparam int DRP_DW = 16;
    localparam int BUS_DW = 32;

    localparam logic [7:0] OFS_ENABLE = 8'h40;
    localparam logic [7:0] OFS_CLKSEL = 8'h44;
    localparam logic [7:0] OFS_CTRL   = 8'h70;
    localparam logic [7:0] OFS_STATUS = 8'h74;

    localparam int CW_SEL      = 29;
    localparam int CW_READ     = 28;
    localparam int CW_ADDR_LSB = 16;
    localparam int ST_BUSY     = 16;

    typedef enum logic [2:0] {
        RSEL_NONE, RSEL_ENABLE, RSEL_CLKSEL, RSEL_CTRL, RSEL_STATUS
    } reg_sel_t;

    typedef enum logic [1:0] {ENG_IDLE, ENG_ISSUE, ENG_WAIT} eng_state_t;

    typedef struct packed {
        logic              rd;
        logic [DRP_AW-1:0] addr;
        logic [DRP_DW-1:0] data;
    } drp_req_t;

    function automatic drp_req_t unpack_ctrl(input logic [BUS_DW-1:0] w);
        drp_req_t r;
        r.rd   = w[CW_READ];
        r.addr = w[CW_ADDR_LSB +: DRP_AW];
        r.data = w[DRP_DW-1:0];
        return r;
    endfunction

    function automatic logic [BUS_DW-1:0] pack_ctrl(input drp_req_t r);
        logic [BUS_DW-1:0] w;
        w = '0;
        w[CW_SEL]                   = 1'b1;
        w[CW_READ]                  = r.rd;
        w[CW_ADDR_LSB +: DRP_AW]    = r.addr;
        w[DRP_DW-1:0]               = r.data;
        return w;
    endfunction
endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode
    import cfgb_pkg::*;
#(
    parameter int BUS_AW = 8
) (
    input  logic [BUS_AW-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        if (addr == BUS_AW'(OFS_ENABLE))      sel = RSEL_ENABLE;
        else if (addr == BUS_AW'(OFS_CLKSEL)) sel = RSEL_CLKSEL;
        else if (addr == BUS_AW'(OFS_CTRL))   sel = RSEL_CTRL;
        else if (addr == BUS_AW'(OFS_STATUS)) sel = RSEL_STATUS;
        else                                  sel = RSEL_NONE;
    end
endmodule

// File: rtl/cfgb_ctrl_regs.sv
module cfgb_ctrl_regs (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_enable,
    input  logic       wr_clksel,
    input  logic [1:0] wdata_lo,
    output logic       core_en_q,
    output logic       synth_en_q,
    output logic       clksel_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            core_en_q  <= 1'b0;
            synth_en_q <= 1'b0;
            clksel_q   <= 1'b0;
        end else begin
            if (wr_enable) begin
                core_en_q  <= wdata_lo[0];
                synth_en_q <= wdata_lo[1];
            end
            if (wr_clksel) clksel_q <= wdata_lo[0];
        end
    end
endmodule

// File: rtl/cfgb_drp_engine.sv
module cfgb_drp_engine
    import cfgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic [DRP_DW-1:0] drp_do,
    input  logic              drp_rdy,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    output logic              busy,
    output logic [DRP_DW-1:0] rd_data,
    output logic [BUS_DW-1:0] ctrl_rb
);
    eng_state_t        state_q;
    drp_req_t          req_q;
    logic [DRP_DW-1:0] rd_data_q;
    logic [BUS_DW-1:0] ctrl_rb_q;
    logic              launch;
    logic              done;

    assign launch = (state_q == ENG_IDLE) && ctrl_wr && wdata[CW_SEL];
    assign done   = (state_q != ENG_IDLE) && drp_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ENG_IDLE;
            req_q     <= '0;
            rd_data_q <= '0;
            ctrl_rb_q <= '0;
        end else begin
            if (launch) begin
                req_q     <= unpack_ctrl(wdata);
                ctrl_rb_q <= pack_ctrl(unpack_ctrl(wdata));
                state_q   <= ENG_ISSUE;
            end else if (done) begin
                if (req_q.rd) rd_data_q <= drp_do;
                state_q <= ENG_IDLE;
            end else if (state_q == ENG_ISSUE) begin
                state_q <= ENG_WAIT;
            end
        end
    end

    assign drp_en   = (state_q == ENG_ISSUE);
    assign drp_we   = (state_q == ENG_ISSUE) && !req_q.rd;
    assign drp_addr = req_q.addr;
    assign drp_di   = req_q.data;
    assign busy     = (state_q != ENG_IDLE);
    assign rd_data  = rd_data_q;
    assign ctrl_rb  = ctrl_rb_q;
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgb_pkg::*;
#(
    parameter int BUS_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              core_enable,
    output logic              synth_enable,
    output logic              clk_sel,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    input  logic [DRP_DW-1:0] drp_do,
    input  logic              drp_rdy
);
    reg_sel_t          sel;
    logic              ctrl_wr;
    logic              eng_busy;
    logic [DRP_DW-1:0] eng_rd_data;
    logic [BUS_DW-1:0] eng_ctrl_rb;
    logic              unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:30], bus_wdata[27:23]};

    cfgb_decode #(.BUS_AW(BUS_AW)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign ctrl_wr = bus_wr_en && (sel == RSEL_CTRL);

    cfgb_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_enable  (bus_wr_en && (sel == RSEL_ENABLE)),
        .wr_clksel  (bus_wr_en && (sel == RSEL_CLKSEL)),
        .wdata_lo   (bus_wdata[1:0]),
        .core_en_q  (core_enable),
        .synth_en_q (synth_enable),
        .clksel_q   (clk_sel)
    );

    cfgb_drp_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wdata    (bus_wdata),
        .drp_do   (drp_do),
        .drp_rdy  (drp_rdy),
        .drp_en   (drp_en),
        .drp_we   (drp_we),
        .drp_addr (drp_addr),
        .drp_di   (drp_di),
        .busy     (eng_busy),
        .rd_data  (eng_rd_data),
        .ctrl_rb  (eng_ctrl_rb)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en) begin
            unique case (sel)
                RSEL_ENABLE: bus_rdata[1:0] = {synth_enable, core_enable};
                RSEL_CLKSEL: bus_rdata[0]   = clk_sel;
                RSEL_CTRL:   bus_rdata      = eng_ctrl_rb;
                RSEL_STATUS: begin
                    bus_rdata[ST_BUSY]      = eng_busy;
                    bus_rdata[DRP_DW-1:0]   = eng_rd_data;
                end
                default:     bus_rdata      = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker
    import cfgb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              drp_en,
    input logic              drp_we,
    input logic              drp_rdy,
    input logic              busy,
    input logic              ctrl_wr,
    input logic              wsel,
    input logic [DRP_AW-1:0] drp_addr,
    input logic [DRP_DW-1:0] drp_di
);
    // R4: one strobe per access
    a_r4_en_one_cycle: assert property (@(posedge clk) disable iff (rst)
        drp_en |=> !drp_en);

    // R5
    a_r5_we_needs_en: assert property (@(posedge clk) disable iff (rst)
        drp_we |-> drp_en);

    // R6: busy begins with the strobe
    a_r6_busy_starts_with_en: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> drp_en);

    // R6: ready ends the busy window
    a_r6_rdy_clears_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && drp_rdy) |=> !busy);

    // R9: request held steady while busy
    a_r9_req_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(drp_addr) && $stable(drp_di)));

    // R8: unselected control write does not launch
    a_r8_no_launch: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_wr && !wsel) |=> !busy);
endmodule

bind cfg_port_bridge cfgb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .drp_en   (drp_en),
    .drp_we   (drp_we),
    .drp_rdy  (drp_rdy),
    .busy     (eng_busy),
    .ctrl_wr  (ctrl_wr),
    .wsel     (bus_wdata[29]),
    .drp_addr (drp_addr),
    .drp_di   (drp_di)
);

// File: tb/cfg_port_bridge_bench.sv
module cfg_port_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_EN = 8'h40, A_CS = 8'h44, A_CT = 8'h70, A_ST = 8'h74;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_enable, synth_enable, clk_sel;
    logic        drp_en, drp_we, drp_rdy;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di, drp_do;

    int vectors = 0, miscompares = 0;
    int en_count = 0;
    int lat_cfg = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_bridge u_cfg_port_bridge (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_enable(core_enable), .synth_enable(synth_enable), .clk_sel(clk_sel),
        .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
        .drp_do(drp_do), .drp_rdy(drp_rdy)
    );

    // behavioural port model
    logic [15:0] mem [128];
    logic [15:0] dout_q;
    logic        pend;
    int          cnt;
    assign drp_rdy = pend && (cnt == 0);
    assign drp_do  = dout_q;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) mem[i] <= 16'hFFFF;
            pend <= 1'b0; cnt <= 0; dout_q <= '0;
        end else if (drp_en) begin
            if (drp_we) mem[drp_addr] <= drp_di;
            dout_q <= mem[drp_addr];
            pend   <= 1'b1;
            cnt    <= lat_cfg;
        end else if (pend) begin
            if (cnt == 0) pend <= 1'b0;
            else cnt <= cnt - 1;
        end
    end

    always @(posedge clk) if (!rst && drp_en) en_count++;

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h0101) ^ 16'h5A3C);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd_en = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    task automatic xact(input logic [31:0] w, input int lat,
                        output int bc, output int ne, output logic [31:0] st);
        int e0;
        lat_cfg = lat;
        e0 = en_count;
        bus_write(A_CT, w);
        bc = 0;
        for (int g = 0; g < 64; g++) begin
            bus_read(A_ST, st);
            if (!st[16]) break;
            bc++;
            @(negedge clk);
        end
        ne = en_count - e0;
    endtask

    function automatic logic [31:0] cw(input bit rd, input int a, input logic [15:0] d);
        return {2'b00, 1'b1, rd, 5'b0, 7'(a), d};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, st, rb;
        int bc, ne;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(A_EN, r); check("R1 enable", r, 0);
        bus_read(A_CS, r); check("R1 clksel", r, 0);
        bus_read(A_CT, r); check("R1 ctrl", r, 0);
        bus_read(A_ST, r); check("R1 status", r, 0);
        check("R1 outputs", {29'b0, core_enable, synth_enable, clk_sel}, 0);
        check("R1 drp strobes", {30'b0, drp_en, drp_we}, 0);

        // R2 / R3 sweep of the low bit combinations
        for (int v = 0; v < 4; v++) begin
            bus_write(A_EN, 32'hFFFF_FFFC | v);
            bus_read(A_EN, r); check("R2 readback", r, v);
            check("R2 pins", {30'b0, synth_enable, core_enable}, v);
        end
        for (int v = 0; v < 2; v++) begin
            bus_write(A_CS, 32'hABCD_EF00 | v);
            bus_read(A_CS, r); check("R3 readback", r, v);
            check("R3 pin", {31'b0, clk_sel}, v);
        end

        // R11 unmapped and idle strobe
        bus_read(8'h48, r); check("R11 unmapped", r, 0);
        bus_rd_en = 1'b0; bus_addr = A_CS; #1 check("R11 rd_en low", bus_rdata, 0);

        // R4 R5 R6 R10: write sweep over every port address
        for (int a = 0; a < 128; a++) begin
            xact(cw(1'b0, a, pat(a)) | 32'hC000_0000, a % 4, bc, ne, st);
            check("R6 busy window", bc, (a % 4) + 2);
            check("R4 one strobe", ne, 1);
            bus_read(A_CT, rb); check("R10 ctrl readback", rb, cw(1'b0, a, pat(a)));
        end
        // R4 R5 visible strobe timing on one access
        lat_cfg = 1;
        bus_write(A_CT, cw(1'b0, 5, pat(5)));
        check("R4 en/we/addr/di", {drp_en, drp_we, 7'(drp_addr), drp_di},
              {1'b1, 1'b1, 7'd5, pat(5)});
        @(negedge clk);
        check("R4 en drops", {31'b0, drp_en}, 0);
        repeat (3) @(negedge clk);

        // R7 read sweep
        for (int a = 0; a < 128; a++) begin
            xact(cw(1'b1, a, 16'h0000), (a + 1) % 4, bc, ne, st);
            check("R7 read data", st, {16'h0000, pat(a)});
            check("R6 read busy", bc, ((a + 1) % 4) + 2);
        end
        lat_cfg = 0;
        bus_write(A_CT, cw(1'b1, 3, 16'h0));
        check("R5 read no we", {drp_en, drp_we}, 2'b10);
        repeat (3) @(negedge clk);

        // R7 a write leaves the read data alone
        xact(cw(1'b0, 20, 16'h7777), 2, bc, ne, st);
        check("R7 write keeps data", st, {16'h0, pat(3)});

        // R8 unselected control write
        ne = en_count;
        bus_write(A_CT, 32'h0000_1234 | (32'd9 << 16));
        bus_read(A_ST, st); check("R8 not busy", st[16], 0);
        repeat (4) @(negedge clk);
        check("R8 no strobe", en_count - ne, 0);
        bus_read(A_CT, rb); check("R8 ctrl unchanged", rb, cw(1'b0, 20, 16'h7777));

        // R9 write while busy
        lat_cfg = 5;
        ne = en_count;
        bus_write(A_CT, cw(1'b0, 10, 16'h1111));
        bus_write(A_CT, cw(1'b0, 11, 16'h2222));
        bus_read(A_CT, rb); check("R9 ctrl keeps first", rb, cw(1'b0, 10, 16'h1111));
        check("R9 addr held", drp_addr, 10);
        repeat (10) @(negedge clk);
        check("R9 single strobe", en_count - ne, 1);
        xact(cw(1'b1, 11, 16'h0), 0, bc, ne, st);
        check("R9 target untouched", st, {16'h0, pat(11)});
        xact(cw(1'b1, 10, 16'h0), 0, bc, ne, st);
        check("R9 first landed", st, {16'h0, 16'h1111});

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule